// File: doc/BRIEF.md
# Register-Controlled Shifter With Carry

A purely combinational 32-bit shifter for shift-by-register operations. A 2-bit select picks one of four operations: logical shift left, logical shift right, arithmetic shift right or rotate right. The shift distance comes from a full 32-bit amount register, but only its least significant byte is used. Alongside the shifted value, the block produces a new carry flag. For distances of zero, exactly the data width, and more than the data width, the carry follows a separate rule for each operation.

The block sits in a datapath between the register read ports and the flag logic. The caller passes in the current carry, so that a zero distance can hand it back unchanged. Merging the carry into a status register and handling immediate-encoded shifts are left to the surrounding logic.

Top module: `regshift_carry`

## Requirements
- R1: Only bits 7:0 of `amount_i` set the distance. Two amounts that share their low byte give the same result and carry for every operand, select and incoming carry.
- R2: For every select, a low byte of zero passes `operand_i` to `result_o` unchanged and copies `carry_i` to `carry_o`.
- R3: With select 00 (logical left) and a distance n from 1 to 31, the result is the operand shifted left by n with zeros filled in, and the carry is operand bit (32 - n).
- R4: With select 00 and a distance of exactly 32, the result is 0 and the carry is operand bit 0. With a distance above 32, the result is 0 and the carry is 0.
- R5: With select 01 (logical right) and a distance n from 1 to 31, the result is the operand shifted right by n with zeros filled in, and the carry is operand bit (n - 1).
- R6: With select 01 and a distance of exactly 32, the result is 0 and the carry is operand bit 31. With a distance above 32, the result is 0 and the carry is 0.
- R7: With select 10 (arithmetic right) and a distance n from 1 to 31, the result is the operand shifted right by n with sign bits filled in, and the carry is operand bit (n - 1). With a distance of 32 or more, every result bit equals operand bit 31, and so does the carry.
- R8: With select 11 (rotate right), the rotation count r is bits 4:0 of the distance. For r from 1 to 31, the result is the operand rotated right by r, and the carry is operand bit (r - 1).
- R9: With select 11, a non-zero distance whose low five bits are zero (32, 64, ..., 224) leaves the result equal to the operand and sets the carry to operand bit 31.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| operand_i | input | 32 | Value to be shifted |
| amount_i | input | 32 | Shift amount register; only the low byte is used |
| op_i | input | 2 | 00 logical left, 01 logical right, 10 arithmetic right, 11 rotate right |
| carry_i | input | 1 | Current carry flag |
| result_o | output | 32 | Shifted value |
| carry_o | output | 1 | New carry flag |

## Verification
The embedded checks are immediate assertions on a combinational path. They assume that every input holds a known two-state value whenever the outputs are evaluated, and that the select is always one of the four defined codes. The bench drives all four inputs together from a single task and only changes them after the previous check has been sampled. It never releases an input to X or Z, and it sweeps only two-state values. Rotation is not checked bit for bit by an assertion. It is checked through its invariant bit count.

// File: rtl/regshift_carry.sv
module regshift_carry #(
  parameter int W  = 32,
  parameter int AW = 8
) (
  input  logic [W-1:0]  operand_i,
  input  logic [W-1:0]  amount_i,
  input  logic [1:0]    op_i,
  input  logic          carry_i,
  output logic [W-1:0]  result_o,
  output logic          carry_o
);
  localparam int LOGW = $clog2(W);

  logic [AW-1:0]   amt;
  logic [LOGW-1:0] rot;

  assign amt = amount_i[AW-1:0];
  assign rot = amt[LOGW-1:0];

  always_comb begin
    result_o = operand_i;
    carry_o  = carry_i;
    if (amt != '0) begin
      unique case (op_i)
        2'b00: begin
          if (int'(amt) < W) begin
            result_o = operand_i << rot;
            carry_o  = operand_i[LOGW'(W - int'(amt))];
          end else if (int'(amt) == W) begin
            result_o = '0;
            carry_o  = operand_i[0];
          end else begin
            result_o = '0;
            carry_o  = 1'b0;
          end
        end
        2'b01: begin
          if (int'(amt) < W) begin
            result_o = operand_i >> rot;
            carry_o  = operand_i[rot - 1'b1];
          end else if (int'(amt) == W) begin
            result_o = '0;
            carry_o  = operand_i[W-1];
          end else begin
            result_o = '0;
            carry_o  = 1'b0;
          end
        end
        2'b10: begin
          if (int'(amt) < W) begin
            result_o = W'($signed(operand_i) >>> rot);
            carry_o  = operand_i[rot - 1'b1];
          end else begin
            result_o = {W{operand_i[W-1]}};
            carry_o  = operand_i[W-1];
          end
        end
        default: begin
          if (rot == '0) begin
            carry_o = operand_i[W-1];
          end else begin
            result_o = (operand_i >> rot) | (operand_i << LOGW'(W - int'(rot)));
            carry_o  = operand_i[rot - 1'b1];
          end
        end
      endcase
    end
  end

  always_comb begin
    if (amt == '0) begin
      p_zero_passthru_r2: assert (result_o == operand_i && carry_o == carry_i)
        else $error("R2: zero distance altered outputs");
    end
    if (op_i == 2'b00 && int'(amt) > W) begin
      p_lsl_flush_r4: assert (result_o == '0 && !carry_o)
        else $error("R4: left shift beyond width not cleared");
    end
    if (op_i == 2'b01 && int'(amt) > W) begin
      p_lsr_flush_r6: assert (result_o == '0 && !carry_o)
        else $error("R6: right shift beyond width not cleared");
    end
    if (op_i == 2'b10 && int'(amt) >= W) begin
      p_asr_fill_r7: assert ($countones(result_o) == (operand_i[W-1] ? W : 0) && carry_o == operand_i[W-1])
        else $error("R7: arithmetic shift did not sign fill");
    end
    if (op_i == 2'b11) begin
      p_ror_keeps_bits_r8: assert ($countones(result_o) == $countones(operand_i))
        else $error("R8: rotate changed bit population");
    end
    if (op_i == 2'b11 && amt != '0 && rot == '0) begin
      p_ror_wrap_carry_r9: assert (result_o == operand_i && carry_o == operand_i[W-1])
        else $error("R9: rotate by width multiple wrong");
    end
  end
endmodule

// File: tb/regshift_carry_tb.sv
module regshift_carry_tb_top;
  logic        clk = 1'b0;
  logic [31:0] operand_i, amount_i;
  logic [1:0]  op_i;
  logic        carry_i;
  logic [31:0] result_o;
  logic        carry_o;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  regshift_carry dut_i (
    .operand_i(operand_i), .amount_i(amount_i), .op_i(op_i),
    .carry_i(carry_i), .result_o(result_o), .carry_o(carry_o)
  );

  function automatic string tag(input logic [1:0] op, input int n);
    if (n == 0) return "R2";
    case (op)
      2'b00:   return (n < 32) ? "R3" : "R4";
      2'b01:   return (n < 32) ? "R5" : "R6";
      2'b10:   return "R7";
      default: return (n % 32 == 0) ? "R9" : "R8";
    endcase
  endfunction

  function automatic logic [32:0] model(input logic [31:0] x, input logic [1:0] op,
                                        input int n, input logic cin);
    logic [63:0] f;
    logic [31:0] r;
    logic c;
    case (op)
      2'b00: begin f = {32'b0, x} << n; r = f[31:0]; c = f[32]; end
      2'b01: begin f = {x, 32'b0} >> n; r = f[63:32]; c = f[31]; end
      2'b10: begin f = 64'($signed({x, 32'b0}) >>> n); r = f[63:32]; c = f[31]; end
      default: begin f = {x, x} >> (n % 32); r = f[31:0]; c = r[31]; end
    endcase
    if (n == 0) begin r = x; c = cin; end
    return {c, r};
  endfunction

  task automatic apply_and_check(input logic [31:0] x, input logic [31:0] a,
                                 input logic [1:0] op, input logic cin, input string req);
    logic [32:0] exp;
    @(posedge clk);
    operand_i = x; amount_i = a; op_i = op; carry_i = cin;
    exp = model(x, op, int'(a[7:0]), cin);
    @(negedge clk);
    checks++;
    if ({carry_o, result_o} !== exp) begin
      errors++;
      $display("FAIL %s op=%b x=%h amt=%h: got c=%b r=%h expected c=%b r=%h",
               req, op, x, a, carry_o, result_o, exp[32], exp[31:0]);
    end
  endtask

  initial begin
    logic [31:0] pats [4];
    logic [31:0] lfsr = 32'hACE1_2468;
    pats[0] = 32'h8000_0001; pats[1] = 32'h7FFF_FFFE;
    pats[2] = 32'hDEAD_BEEF; pats[3] = 32'h1234_5678;
    operand_i = '0; amount_i = '0; op_i = 2'b00; carry_i = 1'b0;
    @(negedge clk);
    checks++;
    if (result_o !== 32'h0 || carry_o !== 1'b0) begin
      errors++;
      $display("FAIL R2 initial: got c=%b r=%h expected c=0 r=0", carry_o, result_o);
    end
    for (int op = 0; op < 4; op++)
      for (int n = 0; n < 256; n++)
        for (int p = 0; p < 4; p++)
          for (int c = 0; c < 2; c++) begin
            lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
            apply_and_check(pats[p], {lfsr[23:0], 8'(n)}, 2'(op), 1'(c), tag(2'(op), n));
          end
    // R1: upper amount bits fully set versus cleared
    for (int op = 0; op < 4; op++)
      for (int n = 0; n < 256; n += 17) begin
        apply_and_check(32'hC3A5_0F96, {24'hFFFFFF, 8'(n)}, 2'(op), 1'b1, "R1");
        apply_and_check(32'hC3A5_0F96, {24'h000000, 8'(n)}, 2'(op), 1'b1, "R1");
      end
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(200000 * 20);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule